// File: doc/BRIEF.md
# Flash Power-Up Block Unlock Scanner

This sequencer prepares a 16-bit NOR flash array for use after power-up. It walks the erase blocks in ascending order. At each block's base address it clears the status, returns the block to array mode, unlocks the block and polls the status word until the device reports ready. Then it reads the status once. If that status shows an erase that was interrupted and left suspended, it resumes the erase and waits for it to finish. Each block ends in array-read mode.

A run begins on its own in the first cycle after reset ends. Later runs begin when `start` is pulsed while the scanner is idle. The number of blocks is taken from `block_count` at the moment a run begins. The base address of a block is computed from its index, a block size parameter and a flash base parameter. Every status poll has a bounded number of tries. When a poll runs out of tries, a sticky error flag is raised and the scanner closes that block and moves on. A one-cycle `done` pulse marks the end of a run.

The flash side is a simple request/acknowledge master. It holds a request until it is acknowledged, with one transfer per acknowledge.

Top module: `flash_unlock_scan`

## Requirements
- R1: A run starts automatically in the first cycle after reset is released. Later, a `start` pulse while idle starts a new run. `block_count` is sampled when the run starts.
- R2: For each block the first four transfers are writes of 0x0050, 0x00FF, 0x0060 and 0x00D0, in that order.
- R3: Every transfer of block i goes to address FLASH_BASE + i*BLOCK_BYTES. Blocks are visited in order i = 0 .. count-1.
- R4: After the 0x00D0 unlock write, the scanner reads the same address repeatedly until a read returns bit 7 set.
- R5: After the unlock poll succeeds, the scanner writes 0x0070 and then makes exactly one read.
- R6: If that single read has bit 6 set, the scanner writes 0x00D0 and then 0x0070, and polls with reads until bit 7 is set. If bit 6 is clear, none of these transfers happen.
- R7: The last transfer of every block is a write of 0x00FF.
- R8: If POLL_TRIES consecutive poll reads all return bit 7 clear, the scanner sets `err_timeout`, writes 0x00FF to that block and continues with the next block. `err_timeout` stays set until the next run starts, and the start of a run clears it.
- R9: `done` is high for exactly one cycle after the final 0x00FF write of the last block is acknowledged. If the block count is zero, `done` pulses within two cycles of the run start and no bus transfer is made.
- R10: A `start` pulse while a run is in progress has no effect on the transfer sequence or on the number of `done` pulses.
- R11: `fl_req` stays high with `fl_we`, `fl_addr` and `fl_wdata` unchanged until a cycle with `fl_ack` high. Exactly one transfer completes in each such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the scanner is idle |
| block_count | input | IDX_W | Number of blocks to scan, sampled at run start |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_timeout | output | 1 | Sticky flag: a status poll ran out of tries |
| fl_req | output | 1 | Flash transfer request |
| fl_we | output | 1 | 1 = write, 0 = read |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | DATA_W | Write data (command word) |
| fl_ack | input | 1 | Transfer acknowledge |
| fl_rdata | input | DATA_W | Read data, valid with `fl_ack` |

## Verification
The bench sweeps block counts from 0 up to the maximum. The flash model varies unlock latency, resume latency and the suspended flag per block, so several cases come up: polls that succeed on the first read, suspended and clean blocks side by side, and polls that never finish. A scanner that misreads a status bit would either skip the resume branch or enter it on a clean block. The transfer log compares order and address word for word, so a wrong index multiply or an off-by-one in the last block shows up as an address or length mismatch. A timeout counted one try early or late, a flag that clears too soon, or a `start` honoured mid-run would show up as a wrong number of poll reads, a lost error or an extra `done` pulse.

// File: rtl/fus_pkg.sv
package fus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_ARR,
    ST_CFG,
    ST_UNL,
    ST_POLL_U,
    ST_RSR,
    ST_STAT,
    ST_RES,
    ST_RSR2,
    ST_POLL_R,
    ST_FIN,
    ST_DONE
  } scan_st_e;

  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_CFG      = 8'h60;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_SUSP_BIT  = 6;

endpackage

// File: rtl/fus_addr_gen.sv
module fus_addr_gen #(
  parameter int              ADDR_W      = 24,
  parameter int              IDX_W       = 8,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter int unsigned     BLOCK_BYTES = 65536
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base_addr
);
  localparam bit IS_POW2 = (BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0;
  localparam int SHIFT   = $clog2(BLOCK_BYTES);

  logic [ADDR_W-1:0] offset;

  generate
    if (IS_POW2) begin : g_shift
      assign offset = ADDR_W'(idx) << SHIFT;
    end else begin : g_mult
      assign offset = ADDR_W'(idx) * ADDR_W'(BLOCK_BYTES);
    end
  endgenerate

  assign base_addr = FLASH_BASE + offset;
endmodule

// File: rtl/fus_poll_timer.sv
module fus_poll_timer #(
  parameter int POLL_TRIES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic last
);
  localparam int CW = (POLL_TRIES < 2) ? 1 : $clog2(POLL_TRIES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(POLL_TRIES - 1));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(POLL_TRIES));
endmodule

// File: rtl/fus_bus_master.sv
module fus_bus_master #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req        <= 1'b0;
      we         <= 1'b0;
      addr       <= '0;
      wdata      <= '0;
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (req) begin
        if (ack) begin
          req        <= 1'b0;
          xfer_done  <= 1'b1;
          xfer_rdata <= rdata;
        end
      end else if (go) begin
        req   <= 1'b1;
        we    <= go_we;
        addr  <= go_addr;
        wdata <= go_wdata;
      end
    end
  end

  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(we) && $stable(addr) && $stable(wdata)));

  p_one_done_per_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> (xfer_done && !req));
endmodule

// File: rtl/flash_unlock_scan.sv
module flash_unlock_scan
  import fus_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                DATA_W      = 16,
  parameter int                IDX_W       = 8,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = '0,
  parameter int unsigned       BLOCK_BYTES = 65536,
  parameter int                POLL_TRIES  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  block_count,
  output logic              done,
  output logic              err_timeout,
  output logic              fl_req,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_rdata
);
  scan_st_e          st;
  logic              pend;
  logic              kick;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  cnt_lat;
  logic [ADDR_W-1:0] blk_addr;

  logic              op_valid;
  logic              op_we;
  logic [7:0]        op_cmd;
  logic              go;
  logic              xfer_done;
  logic [DATA_W-1:0] xfer_rdata;
  logic              rd_ready;
  logic              rd_susp;
  logic              unused_rd_bits;
  logic              is_poll;
  logic              tmr_clr;
  logic              tmr_tick;
  logic              tmr_last;
  logic              launch;
  logic              last_blk;

  fus_addr_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .FLASH_BASE(FLASH_BASE), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_addr (
    .idx(idx), .base_addr(blk_addr)
  );

  always_comb begin
    op_valid = 1'b1;
    op_we    = 1'b1;
    op_cmd   = CMD_ARRAY;
    unique case (st)
      ST_CLR:    op_cmd = CMD_CLR_STAT;
      ST_ARR:    op_cmd = CMD_ARRAY;
      ST_CFG:    op_cmd = CMD_CFG;
      ST_UNL:    op_cmd = CMD_CONFIRM;
      ST_POLL_U: op_we  = 1'b0;
      ST_RSR:    op_cmd = CMD_RD_STAT;
      ST_STAT:   op_we  = 1'b0;
      ST_RES:    op_cmd = CMD_CONFIRM;
      ST_RSR2:   op_cmd = CMD_RD_STAT;
      ST_POLL_R: op_we  = 1'b0;
      ST_FIN:    op_cmd = CMD_ARRAY;
      default:   op_valid = 1'b0;
    endcase
  end

  assign go = op_valid && !pend;

  fus_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst),
    .go(go), .go_we(op_we), .go_addr(blk_addr),
    .go_wdata(DATA_W'(op_cmd)),
    .req(fl_req), .we(fl_we), .addr(fl_addr), .wdata(fl_wdata),
    .ack(fl_ack), .rdata(fl_rdata),
    .xfer_done(xfer_done), .xfer_rdata(xfer_rdata)
  );

  assign rd_ready       = xfer_rdata[STAT_READY_BIT];
  assign rd_susp        = xfer_rdata[STAT_SUSP_BIT];
  assign unused_rd_bits = ^{xfer_rdata[DATA_W-1:8], xfer_rdata[5:0]};

  assign is_poll  = (st == ST_POLL_U) || (st == ST_POLL_R);
  assign tmr_clr  = xfer_done && ((st == ST_UNL) || (st == ST_RSR2));
  assign tmr_tick = xfer_done && is_poll && !rd_ready;

  fus_poll_timer #(.POLL_TRIES(POLL_TRIES)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tmr_tick), .last(tmr_last)
  );

  assign launch   = (st == ST_IDLE) && (kick || start);
  assign last_blk = (idx == cnt_lat - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      pend        <= 1'b0;
      kick        <= 1'b1;
      idx         <= '0;
      cnt_lat     <= '0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) pend <= 1'b1;
      if (launch) begin
        kick        <= 1'b0;
        idx         <= '0;
        cnt_lat     <= block_count;
        err_timeout <= 1'b0;
        st          <= (block_count == '0) ? ST_DONE : ST_CLR;
      end else if (st == ST_DONE) begin
        done <= 1'b1;
        st   <= ST_IDLE;
      end else if (xfer_done) begin
        pend <= 1'b0;
        unique case (st)
          ST_CLR:  st <= ST_ARR;
          ST_ARR:  st <= ST_CFG;
          ST_CFG:  st <= ST_UNL;
          ST_UNL:  st <= ST_POLL_U;
          ST_POLL_U: begin
            if (rd_ready) st <= ST_RSR;
            else if (tmr_last) begin
              err_timeout <= 1'b1;
              st          <= ST_FIN;
            end
          end
          ST_RSR:  st <= ST_STAT;
          ST_STAT: st <= rd_susp ? ST_RES : ST_FIN;
          ST_RES:  st <= ST_RSR2;
          ST_RSR2: st <= ST_POLL_R;
          ST_POLL_R: begin
            if (rd_ready) st <= ST_FIN;
            else if (tmr_last) begin
              err_timeout <= 1'b1;
              st          <= ST_FIN;
            end
          end
          ST_FIN: begin
            if (last_blk) st <= ST_DONE;
            else begin
              idx <= idx + 1'b1;
              st  <= ST_CLR;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_timeout && !launch) |=> err_timeout);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !fl_req);

  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    ((st != ST_IDLE) && (st != ST_DONE)) |-> (idx < cnt_lat));
endmodule

// File: tb/sim_flash_unlock_scan.sv
`timescale 1ns/1ps
module sim_flash_unlock_scan;
  localparam int              AW    = 16;
  localparam int              DW    = 16;
  localparam int              IW    = 4;
  localparam logic [AW-1:0]   BASE  = 16'h1000;
  localparam int              BSZ   = 512;
  localparam int              TRIES = 5;
  localparam int              MAXT  = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [IW-1:0] block_count = '0;
  logic done, err_timeout, fl_req, fl_we, fl_ack;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;

  always #2 clk = ~clk;

  flash_unlock_scan #(
    .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .FLASH_BASE(BASE),
    .BLOCK_BYTES(BSZ), .POLL_TRIES(TRIES)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .block_count(block_count),
    .done(done), .err_timeout(err_timeout),
    .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ack(fl_ack), .fl_rdata(fl_rdata)
  );

  int total = 0;
  int bad = 0;
  int run_id = 0;
  int hang_u = -1;
  int hang_r = -1;
  int ntr = 0;
  int nexp = 0;
  int n_done = 0;
  int cyc = 0;
  logic [32:0] trace_e [MAXT];
  logic [32:0] exp_e [MAXT];
  logic exp_err;
  int cnt70 [16];
  int rdc = 0;
  int lat = 0;
  int wcnt = 0;

  function automatic int ud(int b);
    if (b == hang_u) return 50;
    return (b + run_id) % 4;
  endfunction
  function automatic bit sus(int b);
    return ((b + run_id) % 3) == 0;
  endfunction
  function automatic int rdl(int b);
    if (b == hang_r) return 50;
    return (b * 2 + run_id) % 5;
  endfunction

  // flash model with variable acknowledge latency
  always @(negedge clk) begin
    if (rst) begin
      fl_ack <= 1'b0;
      fl_rdata <= '0;
      wcnt = 0;
    end else if (fl_ack) begin
      fl_ack <= 1'b0;
    end else if (fl_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        int b;
        logic rdy, sp;
        b = (int'(fl_addr) - int'(BASE)) / BSZ;
        if (b < 0 || b > 15) b = 0;
        rdy = 1'b0; sp = 1'b0;
        if (!fl_we) begin
          if (cnt70[b] == 0) rdy = (rdc >= ud(b));
          else if (cnt70[b] == 1) begin rdy = 1'b1; sp = sus(b); end
          else rdy = (rdc >= rdl(b));
          rdc++;
          fl_rdata <= {8'h00, rdy, sp, 6'h00};
        end else begin
          rdc = 0;
          if (fl_wdata == 16'h0050) cnt70[b] = 0;
          if (fl_wdata == 16'h0070) cnt70[b]++;
        end
        fl_ack <= 1'b1;
        if (ntr < MAXT) trace_e[ntr] = {fl_we, fl_addr, fl_we ? fl_wdata : 16'h0000};
        ntr++;
        wcnt = 0;
        lat = ntr % 3;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst && done) n_done++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, actual cyc=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic push(logic we, int b, logic [15:0] d);
    exp_e[nexp] = {we, BASE + AW'(b * BSZ), d};
    nexp++;
  endtask

  // expected sequence derived from R2..R8
  task automatic build_exp(int n);
    nexp = 0;
    exp_err = 1'b0;
    for (int b = 0; b < n; b++) begin
      push(1, b, 16'h0050); push(1, b, 16'h00FF);
      push(1, b, 16'h0060); push(1, b, 16'h00D0);
      if (ud(b) >= TRIES) begin
        for (int k = 0; k < TRIES; k++) push(0, b, 16'h0);
        exp_err = 1'b1;
      end else begin
        for (int k = 0; k <= ud(b); k++) push(0, b, 16'h0);
        push(1, b, 16'h0070); push(0, b, 16'h0);
        if (sus(b)) begin
          push(1, b, 16'h00D0); push(1, b, 16'h0070);
          if (rdl(b) >= TRIES) begin
            for (int k = 0; k < TRIES; k++) push(0, b, 16'h0);
            exp_err = 1'b1;
          end else
            for (int k = 0; k <= rdl(b); k++) push(0, b, 16'h0);
        end
      end
      push(1, b, 16'h00FF);
    end
  endtask

  task automatic check(bit ok, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic compare_trace(string tag);
    check(ntr == nexp, {tag, " R2 R4 R5 R6 R7 R8 transfer count"}, ntr, nexp);
    for (int i = 0; i < nexp && i < ntr; i++) begin
      if (trace_e[i] !== exp_e[i]) begin
        check(0, $sformatf("%s R2 R3 R4 R5 R6 R7 trace[%0d]", tag, i),
              int'(trace_e[i]), int'(exp_e[i]));
        break;
      end
    end
    check(1, "", 0, 0);
  endtask

  task automatic run(int n, bit poke_busy, string tag);
    int t;
    build_exp(n);
    ntr = 0; n_done = 0;
    @(negedge clk);
    block_count = IW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (n_done == 0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (poke_busy && t == 20) begin
        block_count = IW'(n + 3);
        start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(n_done == 1, {tag, " R9 R10 done pulse count"}, n_done, 1);
    compare_trace(tag);
    check(err_timeout == exp_err, {tag, " R8 err_timeout"}, err_timeout, exp_err);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cnt70[i] = 0;
    block_count = '0;
    repeat (3) @(negedge clk);
    // reset state
    check(fl_req == 1'b0, "reset fl_req", fl_req, 0);
    check(done == 1'b0, "reset done", done, 0);
    check(err_timeout == 1'b0, "reset err_timeout", err_timeout, 0);
    rst = 1'b0;
    // R1/R9: automatic run after reset with zero count
    repeat (3) @(negedge clk);
    check(n_done == 1, "R1 R9 auto run zero count done", n_done, 1);
    check(ntr == 0, "R9 zero count no transfer", ntr, 0);
    repeat (5) @(negedge clk);
    check(n_done == 1, "R9 single done after zero run", n_done, 1);

    // sweep of block counts, clean polls
    for (int n = 1; n <= 7; n++) begin
      run_id = n; hang_u = -1; hang_r = -1;
      run(n, 0, $sformatf("sweep n=%0d", n));
    end
    // R8: timeouts in unlock poll and resume poll
    run_id = 6; hang_u = 1; hang_r = 3;
    run(5, 0, "R8 timeout");
    // R8: new run clears sticky error
    hang_u = -1; hang_r = -1; run_id = 2;
    run(2, 0, "R8 clear");
    // R10: start while busy ignored
    run_id = 4;
    run(4, 1, "R10 busy start");
    // R3: largest count
    run_id = 5;
    run(15, 0, "R3 max count");
    // R1: zero count via start
    run(0, 0, "R9 zero start");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule